// File: doc/BRIEF.md
# HyperBus Chip-Select and Clock Timing Generator

This block produces the chip-select, the bus clock and the phase sequence for one HyperBus transfer. A command engine hands it a 32-bit configuration word and a count of 16-bit data beats, then pulses `start`. The generator lowers chip-select and waits out the setup time. It then clocks three CK cycles of command/address, the programmed initial latency and one CK cycle per data beat. After the last falling CK edge it holds chip-select low for the hold time, raises it, and keeps it high for the programmed minimum high time.

Every chip-select interval in the configuration is a whole number of HCLK half-cycles. The block therefore runs on a clock at twice the HCLK rate, and one tick of `clk` is one HCLK half-cycle. CK runs at HCLK/2 (four ticks per period) or HCLK/4 (eight ticks per period).

A transfer may need more chip-select low time than the limit allows, or more beats than the burst group size. In that case the generator splits it into segments. It closes the current segment and waits out the high time. It then opens a new segment with a fresh command/address phase, and reports through `seg_off` how many beats already went out, so the command engine can send the next address. The configuration is captured when a transfer is accepted.

Top module: `hbus_cs_timer`

## Requirements
- R1: After reset, and whenever no transfer is active, `cs_n` is 1, `ck` is 0, `busy` is 0, `done` is 0 and `phase` is 0 (idle).
- R2: From the tick `cs_n` falls, the first rising `ck` comes after 2*s+3 ticks, where s = cfg[1:0].
- R3: Each `ck` high and low half lasts 2 ticks when cfg[15] is 0 and 4 ticks when it is 1. `ck` is 0 whenever `cs_n` is 1.
- R4: A segment of n beats shows exactly 3+L+n rising `ck` edges. L comes from cfg[5:2]: 0→5, 1→6, 2→7, 14→3, 15→4, and every other code gives 7. `phase` reads 2 (command/address) at the first rising edge.
- R5: A segment of n beats keeps `cs_n` low for S+H*(5+2L+2n)+D ticks. Here S is the R2 setup, H is the R3 half length, and D = 2*h+1 ticks with h = cfg[7:6].
- R6: `cs_n` stays high for exactly G = 2*(g+1) ticks between segments, where g = cfg[11:8]. After `done`, `busy` stays 1 for G more ticks.
- R7: Let M = 2*(m+1) ticks, with m = cfg[26:16]. After each beat, a segment takes one more beat only if its low time with that beat would stay within M. Every segment carries at least one beat.
- R8: A segment holds at most B beats, where cfg[13:12] gives 0→64, 1→32, 2→8 and 3→16.
- R9: `seg_start` pulses once per segment, with `seg_off` equal to the beats sent before that segment. `beat_pulse` pulses once per beat, `beats` times in all.
- R10: `done` is a one-tick pulse in the tick the final segment raises `cs_n`, exactly once per transfer.
- R11: `start` is ignored while `busy` is 1, and also when `beats` is 0.
- R12: A change of `cfg` after a transfer is accepted does not alter that transfer's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the HCLK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg | input | 32 | Timing configuration word |
| start | input | 1 | Begin a transfer (accepted when idle) |
| beats | input | BEAT_W | Number of 16-bit data beats |
| cs_n | output | 1 | Chip-select, active low |
| ck | output | 1 | Bus clock |
| phase | output | 3 | 0 idle, 1 setup, 2 cmd/addr, 3 latency, 4 data, 5 hold, 6 high time |
| busy | output | 1 | Transfer or trailing high time in progress |
| done | output | 1 | One-tick pulse when the transfer ends |
| seg_start | output | 1 | One-tick pulse as a segment opens |
| seg_off | output | BEAT_W | Beats already sent when the segment opens |
| beat_pulse | output | 1 | One-tick pulse per data beat |

## Verification
The hardest situation to reach from the ports is a split in which the low-time limit and the burst limit interact with the forced single beat. The stimulus programs very small limits: a maximum low time too short even for one beat, a limit that fits exactly three beats, and an 8-beat burst group. It also requests more beats than one segment can hold. In each case the bench rebuilds the expected segment list from the formulas and compares every segment's low time, edge count, offset and gap. Separate runs change the configuration and pulse `start` in the middle of a transfer, to show that neither has any effect.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
   localparam int CFG_W  = 32;
   localparam int SET_W  = 4;
   localparam int HLD_W  = 4;
   localparam int LAT_W  = 4;
   localparam int GAP_W  = 6;
   localparam int LOW_W  = 13;
   localparam int HALF_W = 3;
   localparam int CAP_W  = 7;
   localparam int CNT_W  = GAP_W;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_CMD   = 3'd2,
      PH_LAT   = 3'd3,
      PH_DATA  = 3'd4,
      PH_HOLD  = 3'd5,
      PH_GAP   = 3'd6
   } phase_t;

   typedef struct packed {
      logic [SET_W-1:0]  setup;
      logic [LAT_W-1:0]  lat;
      logic [HLD_W-1:0]  hold;
      logic [GAP_W-1:0]  gap;
      logic [LOW_W-1:0]  maxlow;
      logic [HALF_W-1:0] half;
      logic [CAP_W-1:0]  cap;
   } timing_t;

   function automatic logic [LAT_W-1:0] lat_cycles(input logic [3:0] code);
      case (code)
         4'd0:    return 4'd5;
         4'd1:    return 4'd6;
         4'd2:    return 4'd7;
         4'd14:   return 4'd3;
         4'd15:   return 4'd4;
         default: return 4'd7;
      endcase
   endfunction
endpackage

// File: rtl/hbt_cfg_decode.sv
module hbt_cfg_decode
   import hbt_pkg::*;
(
   input  logic [CFG_W-1:0] cfg_word,
   output timing_t          tim
);
   logic unused_bits;
   assign unused_bits = ^{cfg_word[31:27], cfg_word[14]};

   always_comb begin
      tim.setup  = SET_W'({1'b0, cfg_word[1:0], 1'b1}) + SET_W'(2);
      tim.lat    = lat_cycles(cfg_word[5:2]);
      tim.hold   = HLD_W'({1'b0, cfg_word[7:6], 1'b1});
      tim.gap    = GAP_W'({1'b0, cfg_word[11:8], 1'b0}) + GAP_W'(2);
      tim.maxlow = LOW_W'({1'b0, cfg_word[26:16], 1'b0}) + LOW_W'(2);
      tim.half   = cfg_word[15] ? HALF_W'(4) : HALF_W'(2);
      case (cfg_word[13:12])
         2'd0:    tim.cap = CAP_W'(64);
         2'd1:    tim.cap = CAP_W'(32);
         2'd2:    tim.cap = CAP_W'(8);
         default: tim.cap = CAP_W'(16);
      endcase
   end
endmodule

// File: rtl/hbt_cfg_hold.sv
module hbt_cfg_hold
   import hbt_pkg::*;
#(
   parameter bit SNAP = 1'b1
)(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  timing_t live,
   output timing_t held
);
   generate
      if (SNAP) begin : g_snap
         timing_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q <= '0;
            else if (load) q <= live;
         end
         assign held = q;
      end else begin : g_live
         logic unused_ctl;
         assign unused_ctl = ^{clk, rst_n, load};
         assign held = live;
      end
   endgenerate
endmodule

// File: rtl/hbt_ck_gen.sv
module hbt_ck_gen
   import hbt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              restart,
   input  logic [HALF_W-1:0] half,
   output logic              ck,
   output logic              tog
);
   logic [HALF_W-1:0] hcnt;
   logic              last_tick;

   assign last_tick = (hcnt == half - HALF_W'(1));
   assign tog       = run && last_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck   <= 1'b0;
         hcnt <= '0;
      end else if (restart) begin
         ck   <= 1'b1;
         hcnt <= '0;
      end else if (run) begin
         if (last_tick) begin
            ck   <= ~ck;
            hcnt <= '0;
         end else begin
            hcnt <= hcnt + HALF_W'(1);
         end
      end else begin
         ck   <= 1'b0;
         hcnt <= '0;
      end
   end

   // R3: inside a half the clock level does not move
   a_r3_half_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !restart && !tog) |=> $stable(ck));
endmodule

// File: rtl/hbt_seq.sv
module hbt_seq
   import hbt_pkg::*;
#(
   parameter int BEAT_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BEAT_W-1:0] beats,
   input  timing_t           tl,
   input  timing_t           th,
   input  logic              ck,
   input  logic              tog,
   output phase_t            st,
   output logic              ck_run,
   output logic              ck_restart,
   output logic              load,
   output logic              seg_start,
   output logic [BEAT_W-1:0] seg_off,
   output logic              beat_pulse,
   output logic              done
);
   localparam int NEED_W = LOW_W + 1;

   logic [CNT_W-1:0]  cnt;
   logic [LAT_W:0]    hrem;
   logic [LOW_W-1:0]  lo_cnt;
   logic [CAP_W-1:0]  seg_beats;
   logic [BEAT_W-1:0] sent;
   logic [BEAT_W-1:0] total;

   logic              cs_low;
   logic [BEAT_W-1:0] sent_nx;
   logic [CAP_W-1:0]  seg_nx;
   logic [NEED_W-1:0] need;
   logic              over, stop;

   assign cs_low     = (st == PH_SETUP) || (st == PH_CMD) || (st == PH_LAT) ||
                       (st == PH_DATA)  || (st == PH_HOLD);
   assign ck_run     = (st == PH_CMD) || (st == PH_LAT) || (st == PH_DATA);
   assign ck_restart = (st == PH_SETUP) && (cnt == '0);
   assign load       = (st == PH_IDLE) && start && (beats != '0);

   assign sent_nx = sent + BEAT_W'(1);
   assign seg_nx  = seg_beats + CAP_W'(1);
   assign need    = NEED_W'(lo_cnt) + NEED_W'(1) + NEED_W'({th.half, 1'b0}) +
                    NEED_W'(th.hold);
   assign over    = need > NEED_W'(th.maxlow);
   assign stop    = (sent_nx == total) || (seg_nx >= th.cap) || over;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= PH_IDLE;
         cnt        <= '0;
         hrem       <= '0;
         lo_cnt     <= '0;
         seg_beats  <= '0;
         sent       <= '0;
         total      <= '0;
         seg_off    <= '0;
         seg_start  <= 1'b0;
         beat_pulse <= 1'b0;
         done       <= 1'b0;
      end else begin
         seg_start  <= 1'b0;
         beat_pulse <= 1'b0;
         done       <= 1'b0;
         if (cs_low) lo_cnt <= lo_cnt + LOW_W'(1);
         case (st)
            PH_IDLE: begin
               if (load) begin
                  total     <= beats;
                  sent      <= '0;
                  seg_beats <= '0;
                  lo_cnt    <= '0;
                  cnt       <= CNT_W'(tl.setup) - CNT_W'(1);
                  seg_off   <= '0;
                  seg_start <= 1'b1;
                  st        <= PH_SETUP;
               end
            end
            PH_SETUP: begin
               if (cnt == '0) begin
                  hrem <= (LAT_W+1)'(5);
                  st   <= PH_CMD;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            PH_CMD: begin
               if (tog) begin
                  if (hrem == '0) begin
                     hrem <= (LAT_W+1)'({th.lat, 1'b0}) - (LAT_W+1)'(1);
                     st   <= PH_LAT;
                  end else begin
                     hrem <= hrem - (LAT_W+1)'(1);
                  end
               end
            end
            PH_LAT: begin
               if (tog) begin
                  if (hrem == '0) st <= PH_DATA;
                  else            hrem <= hrem - (LAT_W+1)'(1);
               end
            end
            PH_DATA: begin
               if (tog && ck) begin
                  beat_pulse <= 1'b1;
                  sent       <= sent_nx;
                  seg_beats  <= seg_nx;
                  if (stop) begin
                     cnt <= CNT_W'(th.hold) - CNT_W'(1);
                     st  <= PH_HOLD;
                  end
               end
            end
            PH_HOLD: begin
               if (cnt == '0) begin
                  cnt <= CNT_W'(th.gap) - CNT_W'(1);
                  if (sent == total) done <= 1'b1;
                  st  <= PH_GAP;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            PH_GAP: begin
               if (cnt == '0) begin
                  if (sent != total) begin
                     seg_beats <= '0;
                     lo_cnt    <= '0;
                     cnt       <= CNT_W'(th.setup) - CNT_W'(1);
                     seg_off   <= sent;
                     seg_start <= 1'b1;
                     st        <= PH_SETUP;
                  end else begin
                     st <= PH_IDLE;
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: st <= PH_IDLE;
         endcase
      end
   end

   // R10: completion is a single-tick pulse
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7: a segment with more than one beat never outlasts the low-time limit
   a_r7_low_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_HOLD && cnt == '0 && seg_beats > CAP_W'(1)) |->
      (NEED_W'(lo_cnt) + NEED_W'(1) <= NEED_W'(th.maxlow)));
   // R8: the data phase never runs past the burst group
   a_r8_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_DATA) |-> (seg_beats < th.cap));
   // R5: the bus clock rests low through the hold time
   a_r5_hold_ck_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_HOLD) |-> !ck);
   // R11: a zero-beat request leaves the sequencer idle
   a_r11_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_IDLE && start && beats == '0) |=> (st == PH_IDLE));
endmodule

// File: rtl/hbus_cs_timer.sv
module hbus_cs_timer
   import hbt_pkg::*;
#(
   parameter int BEAT_W   = 8,
   parameter bit SNAP_CFG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cfg,
   input  logic              start,
   input  logic [BEAT_W-1:0] beats,
   output logic              cs_n,
   output logic              ck,
   output logic [2:0]        phase,
   output logic              busy,
   output logic              done,
   output logic              seg_start,
   output logic [BEAT_W-1:0] seg_off,
   output logic              beat_pulse
);
   generate
      if (BEAT_W < 2 || BEAT_W > 16) begin : g_bad_beat_w
         $error("hbus_cs_timer: BEAT_W must lie in 2..16");
      end
   endgenerate

   timing_t tim_live, tim_held;
   phase_t  st;
   logic    ck_run, ck_restart, load, tog;

   hbt_cfg_decode u_dec (
      .cfg_word (cfg),
      .tim      (tim_live)
   );

   hbt_cfg_hold #(.SNAP(SNAP_CFG)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .live  (tim_live),
      .held  (tim_held)
   );

   hbt_ck_gen u_ck (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ck_run),
      .restart (ck_restart),
      .half    (tim_held.half),
      .ck      (ck),
      .tog     (tog)
   );

   hbt_seq #(.BEAT_W(BEAT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .beats      (beats),
      .tl         (tim_live),
      .th         (tim_held),
      .ck         (ck),
      .tog        (tog),
      .st         (st),
      .ck_run     (ck_run),
      .ck_restart (ck_restart),
      .load       (load),
      .seg_start  (seg_start),
      .seg_off    (seg_off),
      .beat_pulse (beat_pulse),
      .done       (done)
   );

   assign cs_n  = (st == PH_IDLE) || (st == PH_GAP);
   assign busy  = (st != PH_IDLE);
   assign phase = st;

   // R3: no clock activity while chip-select is released
   a_r3_ck_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !ck);
   // R1: the idle phase code always reads as not busy
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd0) |-> (!busy && !done && cs_n));
endmodule

// File: tb/sim_hbus_cs_timer.sv
module sim_hbus_cs_timer;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   cfg = '0;
   logic          start = 1'b0;
   logic [BW-1:0] beats = '0;
   logic          cs_n, ck, busy, done, seg_start, beat_pulse;
   logic [2:0]    phase;
   logic [BW-1:0] seg_off;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   hbus_cs_timer #(.BEAT_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .start(start), .beats(beats),
      .cs_n(cs_n), .ck(ck), .phase(phase), .busy(busy), .done(done),
      .seg_start(seg_start), .seg_off(seg_off), .beat_pulse(beat_pulse)
   );

   // measurements of one transfer
   int m_segs, m_beats, m_dones, m_tail, m_maxhi, m_phase_bad, m_seg_pulses;
   int m_low[0:31];
   int m_setup[0:31];
   int m_rise[0:31];
   int m_gap[0:31];
   int m_off[0:31];
   // expectation
   int e_segs;
   int e_n[0:31];
   int e_off[0:31];

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int s, input int l, input int h, input int g,
                                      input int b, input int dv, input int m);
      return {5'd0, 11'(m), 1'(dv), 1'b0, 2'(b), 4'(g), 2'(h), 4'(l), 2'(s)};
   endfunction

   function automatic int f_setup(input logic [31:0] c); return 2*int'(c[1:0]) + 3; endfunction
   function automatic int f_hold(input logic [31:0] c);  return 2*int'(c[7:6]) + 1; endfunction
   function automatic int f_gap(input logic [31:0] c);   return 2*(int'(c[11:8]) + 1); endfunction
   function automatic int f_maxl(input logic [31:0] c);  return 2*(int'(c[26:16]) + 1); endfunction
   function automatic int f_half(input logic [31:0] c);  return c[15] ? 4 : 2; endfunction
   function automatic int f_lat(input logic [31:0] c);
      case (c[5:2])
         4'd0: return 5;  4'd1: return 6;  4'd2: return 7;
         4'd14: return 3; 4'd15: return 4;
         default: return 7;
      endcase
   endfunction
   function automatic int f_cap(input logic [31:0] c);
      case (c[13:12])
         2'd0: return 64; 2'd1: return 32; 2'd2: return 8;
         default: return 16;
      endcase
   endfunction
   function automatic int f_low(input logic [31:0] c, input int n);
      return f_setup(c) + f_half(c)*(5 + 2*f_lat(c) + 2*n) + f_hold(c);
   endfunction

   task automatic plan(input logic [31:0] c, input int nb);
      int rem = nb;
      int off = 0;
      e_segs = 0;
      while (rem > 0 && e_segs < 32) begin
         int n = 1;
         while (n < rem && n < f_cap(c) &&
                f_setup(c) + f_half(c)*(5 + 2*f_lat(c) + 2*n) + 2*f_half(c) + f_hold(c) <= f_maxl(c))
            n++;
         e_n[e_segs] = n;
         e_off[e_segs] = off;
         e_segs++;
         off += n;
         rem -= n;
      end
   endtask

   // drive one transfer and record what the ports show; optional mid-run poke
   task automatic run_txn(input logic [31:0] c, input int nb, input int poke_at,
                          input logic [31:0] poke_cfg, input bit poke_start);
      bit prev_cs = 1'b1;
      bit prev_ck = 1'b0;
      bit seen_rise = 1'b0;
      bit after_done = 1'b0;
      int hi_run = 0;
      int idx = 0;
      m_segs = 0; m_beats = 0; m_dones = 0; m_tail = 0; m_maxhi = 0;
      m_phase_bad = 0; m_seg_pulses = 0;
      for (int i = 0; i < 32; i++) begin
         m_low[i] = 0; m_setup[i] = 0; m_rise[i] = 0; m_gap[i] = 0; m_off[i] = -1;
      end
      @(negedge clk);
      cfg = c; beats = BW'(nb); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (idx < 20000) begin
         if (!busy) break;
         if (idx == poke_at) begin
            cfg = poke_cfg;
            if (poke_start) begin start = 1'b1; beats = BW'(7); end
         end
         if (idx == poke_at + 1) start = 1'b0;
         if (done) begin m_dones++; after_done = 1'b1; end
         if (!cs_n) begin
            if (prev_cs) begin
               m_segs++;
               seen_rise = 1'b0;
            end
            if (m_segs > 0 && m_segs <= 32) begin
               m_low[m_segs-1]++;
               if (!seen_rise && !ck) m_setup[m_segs-1]++;
               if (ck && !prev_ck) begin
                  m_rise[m_segs-1]++;
                  if (!seen_rise) begin
                     seen_rise = 1'b1;
                     if (phase != 3'd2) m_phase_bad++;
                  end
               end
            end
         end else begin
            if (after_done) m_tail++;
            else if (m_segs > 0 && m_segs <= 32) m_gap[m_segs-1]++;
         end
         if (seg_start) begin
            m_seg_pulses++;
            if (m_segs > 0 && m_segs <= 32) m_off[m_segs-1] = int'(seg_off);
         end
         if (beat_pulse) m_beats++;
         if (ck) begin hi_run++; if (hi_run > m_maxhi) m_maxhi = hi_run; end
         else hi_run = 0;
         prev_cs = cs_n;
         prev_ck = ck;
         idx++;
         @(negedge clk);
      end
      if (idx >= 20000) chk("R10", "transfer never ended", 1, 0);
   endtask

   task automatic check_txn(input string name, input logic [31:0] c, input int nb,
                            input int poke_at, input logic [31:0] poke_cfg, input bit poke_start);
      run_txn(c, nb, poke_at, poke_cfg, poke_start);
      plan(c, nb);
      chk("R7", {name, " segment count"}, m_segs, e_segs);
      chk("R9", {name, " seg_start pulses"}, m_seg_pulses, e_segs);
      chk("R9", {name, " beat pulses"}, m_beats, nb);
      chk("R10", {name, " done pulses"}, m_dones, 1);
      chk("R6", {name, " trailing busy ticks"}, m_tail, f_gap(c));
      chk("R3", {name, " ck half length"}, m_maxhi, f_half(c));
      chk("R4", {name, " phase at first rise"}, m_phase_bad, 0);
      for (int i = 0; i < e_segs && i < m_segs; i++) begin
         chk("R2", $sformatf("%s seg%0d setup", name, i), m_setup[i], f_setup(c));
         chk("R4", $sformatf("%s seg%0d ck rises", name, i), m_rise[i], 3 + f_lat(c) + e_n[i]);
         chk("R5", $sformatf("%s seg%0d low ticks", name, i), m_low[i], f_low(c, e_n[i]));
         chk("R9", $sformatf("%s seg%0d offset", name, i), m_off[i], e_off[i]);
         if (i < e_segs - 1)
            chk("R6", $sformatf("%s seg%0d gap", name, i), m_gap[i], f_gap(c));
      end
   endtask

   task automatic t_reset;
      chk("R1", "cs_n at reset", int'(cs_n), 1);
      chk("R1", "ck at reset", int'(ck), 0);
      chk("R1", "busy at reset", int'(busy), 0);
      chk("R1", "done at reset", int'(done), 0);
      chk("R1", "phase at reset", int'(phase), 0);
   endtask

   task automatic t_basic;
      check_txn("basic", mk(0, 0, 0, 0, 0, 0, 2047), 4, -1, '0, 1'b0);
      chk("R1", "cs_n after transfer", int'(cs_n), 1);
      chk("R1", "ck after transfer", int'(ck), 0);
   endtask

   task automatic t_div4;
      check_txn("div4", mk(3, 15, 3, 2, 0, 1, 2047), 3, -1, '0, 1'b0);
   endtask

   task automatic t_latency;
      check_txn("lat3", mk(1, 14, 0, 0, 0, 0, 2047), 1, -1, '0, 1'b0);
      check_txn("lat7", mk(2, 2, 2, 1, 0, 0, 2047), 2, -1, '0, 1'b0);
      check_txn("lat_reserved", mk(0, 5, 1, 0, 3, 0, 2047), 1, -1, '0, 1'b0);
   endtask

   task automatic t_split_low;
      // R7: limit of 40 ticks fits three beats per segment
      check_txn("split_low", mk(0, 14, 0, 5, 0, 0, 19), 10, -1, '0, 1'b0);
   endtask

   task automatic t_burst;
      // R8: 8-beat group with generous low-time limit
      check_txn("burst8", mk(1, 1, 1, 0, 2, 0, 2047), 20, -1, '0, 1'b0);
   endtask

   task automatic t_forced;
      // R7: limit too short for any beat still moves one beat per segment
      check_txn("forced", mk(0, 0, 0, 0, 0, 0, 0), 2, -1, '0, 1'b0);
   endtask

   task automatic t_ignore;
      int woke = 0;
      @(negedge clk);
      beats = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 20; i++) begin
         if (cs_n !== 1'b1 || busy !== 1'b0) woke++;
         @(negedge clk);
      end
      chk("R11", "zero-beat start ignored", woke, 0);
      // R11: a second start mid-transfer must not change the beat total
      check_txn("busy_start", mk(0, 0, 0, 0, 0, 0, 2047), 3, 10,
                mk(0, 0, 0, 0, 0, 0, 2047), 1'b1);
   endtask

   task automatic t_snapshot;
      // R12: configuration rewritten while the transfer runs
      check_txn("snapshot", mk(1, 0, 1, 3, 2, 1, 2047), 12, 5,
                mk(3, 2, 3, 15, 0, 0, 5), 1'b0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_basic();
      t_div4();
      t_latency();
      t_split_low();
      t_burst();
      t_forced();
      t_ignore();
      t_snapshot();
      repeat (5) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule